// File: doc/BRIEF.md
# Superscalar Dispatch and Rename Stage

This block sits between the dispatch queue and the execution units of an out-of-order core. Each cycle it looks at a group of up to four decoded instructions, oldest in slot 0. In one cycle it dispatches the longest run of those slots that can be placed, starting from the oldest. Every dispatched instruction gets its own reorder-buffer entry. Every dispatched instruction that writes a register also gets a rename-buffer entry, whose index is the destination tag.

Each source operand is resolved in one of three ways, in this priority:
- If an older instruction in the same group writes that register, the operand is that instruction's destination tag.
- Otherwise, if the rename buffers hold the register, the youngest matching entry is used. It supplies its value once its result is ready, and its tag until then.
- Otherwise, the architectural register file supplies the value. The file is read through ports, one read address per operand.

The block reports how many queue slots it consumed, so that the fetch side can refill them.

Result write-back into rename entries, in-order retirement and pipeline flush arrive as plain inputs. Retirement frees the oldest reorder-buffer entry. If that entry holds a destination, retirement also produces a register-file write from its rename entry. A flush discards every rename allocation that has not retired, and moves the reorder-buffer allocation pointer back to the retire pointer.

Top module: `disp_rename_stage`

## Requirements
- R1: After reset the reorder buffer and rename buffers are empty. A full group with no destinations dispatches all four slots with reorder tags 0, 1, 2 and 3.
- R2: The slot valid bits are indexed with slot 0 as the oldest. The dispatched slots always form an unbroken run from slot 0, and dispatch stops at the first invalid slot.
- R3: The reorder tag of slot i is the allocation pointer plus i, modulo the reorder depth. The pointer then advances by the number of slots dispatched.
- R4: Destination tags go to the destination-writing slots in slot order. They are consecutive from the rename allocation pointer, modulo the rename depth. Slots without a destination consume no tag.
- R5: A source that matches the destination register of an older dispatched slot in the same group is marked not ready, and carries the tag of the youngest such slot.
- R6: Any other source that matches a valid rename entry uses the youngest match, meaning the one allocated last. If that entry's result is ready, the operand is ready with its value; if not, the operand is not ready and carries its tag.
- R7: A source with no match in the group or in the rename buffers is ready, with the register-file value read at its own read address.
- R8: A slot dispatches only if the reorder buffer has room for it and every older dispatched slot. It also needs rename room for its destination together with those of the older dispatched slots. If either check fails, that slot and all younger slots are held.
- R9: The freed-slot count equals the number of slots dispatched in that cycle.
- R10: A write-back marks its rename entry ready and stores the value. A later lookup of that register then returns the value as ready.
- R11: A retire request with a non-empty reorder buffer frees the oldest entry. If that entry has a destination, the same cycle produces a register-file write of the entry's register and value.
- R12: During a flush cycle nothing dispatches. Afterwards no rename entry is valid, the reorder buffer is empty, and lookups fall through to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard all unretired allocations |
| grp_vld | input | G (4) | Slot valid, bit 0 oldest |
| grp_dst_en | input | G (4) | Slot writes a destination register |
| grp_dst | input | G×AW (4×5) | Destination register number per slot |
| grp_src | input | G×2×AW (4×2×5) | Two source register numbers per slot |
| rf_addr | output | G×2×AW (4×2×5) | Register-file read address per operand |
| rf_data | input | G×2×DW (4×2×32) | Register-file read data per operand |
| wb_vld | input | 1 | Result write-back strobe |
| wb_tag | input | RTW (3) | Rename entry being written |
| wb_data | input | DW (32) | Result value |
| ret_vld | input | 1 | Retire the oldest reorder entry |
| disp_vld | output | G (4) | Slot dispatched this cycle |
| disp_rob | output | G×QTW (4×4) | Reorder tag per slot |
| disp_tag | output | G×RTW (4×3) | Destination rename tag per slot |
| opnd_rdy | output | G×2 (4×2) | Operand carries a value |
| opnd_val | output | G×2×DW (4×2×32) | Operand value when ready |
| opnd_tag | output | G×2×RTW (4×2×3) | Producer tag when not ready |
| slots_freed | output | CW (3) | Queue slots consumed this cycle |
| ret_wr_en | output | 1 | Register-file write from retirement |
| ret_wr_reg | output | AW (5) | Register written at retirement |
| ret_wr_data | output | DW (32) | Value written at retirement |

## Verification
The assertions assume three things about the inputs:
- A write-back only targets a rename entry that is currently allocated and whose result is not yet ready.
- A retire request is only raised when the oldest reorder entry either has no destination or has a result that is ready.
- The register-file data matches the addresses driven in the same cycle.

The stimulus enforces these from its own model of the entries. It picks write-back targets only among allocated entries that are not ready. It raises retirement only when its model shows the head entry is complete. It feeds the read data combinationally from its own register array, which is updated by the retirement writes.

// File: rtl/drs_pkg.sv
package drs_pkg;
   typedef enum logic [1:0] {
      SRC_ARCH   = 2'd0,
      SRC_RENAME = 2'd1,
      SRC_GROUP  = 2'd2
   } src_sel_e;
endpackage

// File: rtl/drs_alloc_ctrl.sv
module drs_alloc_ctrl #(
   parameter int G     = 4,
   parameter int REN_D = 8,
   parameter int ROB_D = 16,
   localparam int RTW  = $clog2(REN_D),
   localparam int QTW  = $clog2(ROB_D),
   localparam int CW   = $clog2(G + 1)
) (
   input  logic                  flush,
   input  logic [G-1:0]          grp_vld,
   input  logic [G-1:0]          grp_dst_en,
   input  logic [QTW:0]          rob_n,
   input  logic [RTW:0]          ren_n,
   output logic [G-1:0]          disp_vld,
   output logic [G-1:0][RTW-1:0] dst_ofs,
   output logic [CW-1:0]         n_disp,
   output logic [CW-1:0]         n_dst
);
   int   acc;
   int   nd;
   logic go;

   // Oldest-first scan; the first slot that cannot be placed closes the group.
   always_comb begin
      go       = !flush;
      acc      = 0;
      nd       = 0;
      disp_vld = '0;
      for (int i = 0; i < G; i++) begin
         dst_ofs[i] = RTW'(acc);
         if (go && grp_vld[i]
             && (int'(rob_n) + i + 1 <= ROB_D)
             && (int'(ren_n) + acc + int'(grp_dst_en[i]) <= REN_D)) begin
            disp_vld[i] = 1'b1;
            acc         = acc + int'(grp_dst_en[i]);
            nd          = i + 1;
         end else begin
            go = 1'b0;
         end
      end
      n_disp = CW'(nd);
      n_dst  = CW'(acc);
   end
endmodule

// File: rtl/drs_operand_lookup.sv
module drs_operand_lookup
   import drs_pkg::*;
#(
   parameter int AW    = 5,
   parameter int DW    = 32,
   parameter int REN_D = 8,
   localparam int RTW  = $clog2(REN_D)
) (
   input  logic [AW-1:0]             src,
   input  logic                      grp_hit,
   input  logic [RTW-1:0]            grp_tag,
   input  logic [REN_D-1:0]          ren_v,
   input  logic [REN_D-1:0]          ren_rdy,
   input  logic [REN_D-1:0][AW-1:0]  ren_arch,
   input  logic [REN_D-1:0][DW-1:0]  ren_val,
   input  logic [RTW-1:0]            ren_t,
   input  logic [DW-1:0]             rf_val,
   output logic                      rdy,
   output logic [DW-1:0]             val,
   output logic [RTW-1:0]            tag
);
   src_sel_e       sel;
   logic           r_hit;
   logic [RTW-1:0] r_tag;
   logic [RTW-1:0] best_age;
   logic [RTW-1:0] age;

   // Youngest match = largest distance from the free (oldest) pointer.
   always_comb begin
      r_hit    = 1'b0;
      r_tag    = '0;
      best_age = '0;
      age      = '0;
      for (int k = 0; k < REN_D; k++) begin
         age = RTW'(k) - ren_t;
         if (ren_v[k] && ren_arch[k] == src && (!r_hit || age > best_age)) begin
            r_hit    = 1'b1;
            r_tag    = RTW'(k);
            best_age = age;
         end
      end
      if (grp_hit)    sel = SRC_GROUP;
      else if (r_hit) sel = SRC_RENAME;
      else            sel = SRC_ARCH;
   end

   always_comb begin
      rdy = 1'b1;
      val = rf_val;
      tag = '0;
      unique case (sel)
         SRC_GROUP: begin
            rdy = 1'b0;
            tag = grp_tag;
         end
         SRC_RENAME: begin
            rdy = ren_rdy[r_tag];
            val = ren_val[r_tag];
            tag = r_tag;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/disp_rename_stage.sv
module disp_rename_stage #(
   parameter int G     = 4,
   parameter int NARCH = 32,
   parameter int DW    = 32,
   parameter int REN_D = 8,
   parameter int ROB_D = 16,
   localparam int AW   = $clog2(NARCH),
   localparam int RTW  = $clog2(REN_D),
   localparam int QTW  = $clog2(ROB_D),
   localparam int CW   = $clog2(G + 1),
   localparam int NS   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [G-1:0]                  grp_vld,
   input  logic [G-1:0]                  grp_dst_en,
   input  logic [G-1:0][AW-1:0]          grp_dst,
   input  logic [G-1:0][NS-1:0][AW-1:0]  grp_src,
   output logic [G-1:0][NS-1:0][AW-1:0]  rf_addr,
   input  logic [G-1:0][NS-1:0][DW-1:0]  rf_data,
   input  logic                          wb_vld,
   input  logic [RTW-1:0]                wb_tag,
   input  logic [DW-1:0]                 wb_data,
   input  logic                          ret_vld,
   output logic [G-1:0]                  disp_vld,
   output logic [G-1:0][QTW-1:0]         disp_rob,
   output logic [G-1:0][RTW-1:0]         disp_tag,
   output logic [G-1:0][NS-1:0]          opnd_rdy,
   output logic [G-1:0][NS-1:0][DW-1:0]  opnd_val,
   output logic [G-1:0][NS-1:0][RTW-1:0] opnd_tag,
   output logic [CW-1:0]                 slots_freed,
   output logic                          ret_wr_en,
   output logic [AW-1:0]                 ret_wr_reg,
   output logic [DW-1:0]                 ret_wr_data
);
   if (G < 1) begin : g_bad_group
      $error("group width must be at least one slot");
   end
   if ((REN_D & (REN_D - 1)) != 0 || REN_D < 2) begin : g_bad_ren
      $error("rename depth must be a power of two");
   end
   if ((ROB_D & (ROB_D - 1)) != 0 || ROB_D < 2) begin : g_bad_rob
      $error("reorder depth must be a power of two");
   end

   // Rename buffer storage (circular, allocated and freed in order)
   logic [REN_D-1:0]          ren_v, ren_rdy;
   logic [REN_D-1:0][AW-1:0]  ren_arch;
   logic [REN_D-1:0][DW-1:0]  ren_val;
   logic [RTW-1:0]            ren_h, ren_t, ren_h_nx, ren_t_nx;
   logic [RTW:0]              ren_n, ren_n_nx;
   // Reorder buffer storage
   logic [ROB_D-1:0]          rob_has;
   logic [ROB_D-1:0][RTW-1:0] rob_tag;
   logic [QTW-1:0]            rob_h, rob_t, rob_h_nx, rob_t_nx;
   logic [QTW:0]              rob_n, rob_n_nx;

   logic [G-1:0][RTW-1:0]     dst_ofs, dtag;
   logic [CW-1:0]             n_disp, n_dst;
   logic [G-1:0][NS-1:0]      g_hit;
   logic [G-1:0][NS-1:0][RTW-1:0] g_tag;
   logic                      ret_go, ret_free;
   logic [RTW-1:0]            ret_tag;

   drs_alloc_ctrl #(.G(G), .REN_D(REN_D), .ROB_D(ROB_D)) u_alloc (
      .flush     (flush),
      .grp_vld   (grp_vld),
      .grp_dst_en(grp_dst_en),
      .rob_n     (rob_n),
      .ren_n     (ren_n),
      .disp_vld  (disp_vld),
      .dst_ofs   (dst_ofs),
      .n_disp    (n_disp),
      .n_dst     (n_dst)
   );

   assign slots_freed = n_disp;
   assign rf_addr     = grp_src;

   // Tags per slot and same-group producer search (youngest older writer wins)
   always_comb begin
      for (int i = 0; i < G; i++) begin
         dtag[i]     = ren_h + dst_ofs[i];
         disp_tag[i] = dtag[i];
         disp_rob[i] = rob_h + QTW'(i);
      end
      for (int i = 0; i < G; i++) begin
         for (int s = 0; s < NS; s++) begin
            g_hit[i][s] = 1'b0;
            g_tag[i][s] = '0;
            for (int j = 0; j < i; j++) begin
               if (grp_dst_en[j] && grp_dst[j] == grp_src[i][s]) begin
                  g_hit[i][s] = 1'b1;
                  g_tag[i][s] = dtag[j];
               end
            end
         end
      end
   end

   for (genvar gi = 0; gi < G; gi++) begin : g_slot
      for (genvar gs = 0; gs < NS; gs++) begin : g_src
         drs_operand_lookup #(.AW(AW), .DW(DW), .REN_D(REN_D)) u_lookup (
            .src     (grp_src[gi][gs]),
            .grp_hit (g_hit[gi][gs]),
            .grp_tag (g_tag[gi][gs]),
            .ren_v   (ren_v),
            .ren_rdy (ren_rdy),
            .ren_arch(ren_arch),
            .ren_val (ren_val),
            .ren_t   (ren_t),
            .rf_val  (rf_data[gi][gs]),
            .rdy     (opnd_rdy[gi][gs]),
            .val     (opnd_val[gi][gs]),
            .tag     (opnd_tag[gi][gs])
         );
      end
   end

   // Retirement of the oldest reorder entry
   assign ret_go      = ret_vld && (rob_n != '0);
   assign ret_free    = ret_go && rob_has[rob_t];
   assign ret_tag     = rob_tag[rob_t];
   assign ret_wr_en   = ret_free;
   assign ret_wr_reg  = ren_arch[ret_tag];
   assign ret_wr_data = ren_val[ret_tag];

   always_comb begin
      rob_t_nx = rob_t + QTW'(ret_go);
      ren_t_nx = ren_t + RTW'(ret_free);
      if (flush) begin
         rob_h_nx = rob_t_nx;
         rob_n_nx = '0;
         ren_h_nx = ren_t_nx;
         ren_n_nx = '0;
      end else begin
         rob_h_nx = rob_h + QTW'(n_disp);
         rob_n_nx = rob_n + (QTW+1)'(n_disp) - (QTW+1)'(ret_go);
         ren_h_nx = ren_h + RTW'(n_dst);
         ren_n_nx = ren_n + (RTW+1)'(n_dst) - (RTW+1)'(ret_free);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rob_h <= '0; rob_t <= '0; rob_n <= '0;
         ren_h <= '0; ren_t <= '0; ren_n <= '0;
      end else begin
         rob_h <= rob_h_nx; rob_t <= rob_t_nx; rob_n <= rob_n_nx;
         ren_h <= ren_h_nx; ren_t <= ren_t_nx; ren_n <= ren_n_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ren_v    <= '0;
         ren_rdy  <= '0;
         ren_arch <= '0;
         ren_val  <= '0;
         rob_has  <= '0;
         rob_tag  <= '0;
      end else begin
         if (ret_free)
            ren_v[ret_tag] <= 1'b0;
         if (wb_vld) begin
            ren_rdy[wb_tag] <= 1'b1;
            ren_val[wb_tag] <= wb_data;
         end
         for (int i = 0; i < G; i++) begin
            if (disp_vld[i]) begin
               rob_has[disp_rob[i]] <= grp_dst_en[i];
               rob_tag[disp_rob[i]] <= dtag[i];
               if (grp_dst_en[i]) begin
                  ren_v[dtag[i]]    <= 1'b1;
                  ren_rdy[dtag[i]]  <= 1'b0;
                  ren_arch[dtag[i]] <= grp_dst[i];
               end
            end
         end
         if (flush)
            ren_v <= '0;
      end
   end
endmodule

// File: rtl/drs_chk.sv
module drs_chk #(
   parameter int G     = 4,
   parameter int REN_D = 8,
   parameter int ROB_D = 16,
   localparam int RTW  = $clog2(REN_D),
   localparam int QTW  = $clog2(ROB_D),
   localparam int CW   = $clog2(G + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             ret_vld,
   input logic [G-1:0]     disp_vld,
   input logic [CW-1:0]    slots_freed,
   input logic             ret_wr_en,
   input logic [QTW:0]     rob_n,
   input logic [RTW:0]     ren_n,
   input logic [REN_D-1:0] ren_v
);
   // R2: dispatched slots are a contiguous run from the oldest slot
   p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_vld & (disp_vld + 1'b1)) == '0);

   // R9: freed count agrees with the per-slot dispatch flags
   p_freed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(slots_freed) == $countones(disp_vld));

   // R8: occupancy never passes the configured depth
   p_rob_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rob_n) <= ROB_D);

   // R8: rename occupancy counter matches the valid entries
   p_ren_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ren_v) == int'(ren_n));

   // R3: without flush or retire, occupancy grows by the dispatched count
   p_rob_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !ret_vld) |=> rob_n == $past(rob_n) + (QTW+1)'($past(slots_freed)));

   // R12: nothing dispatches in a flush cycle
   p_flush_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> disp_vld == '0);

   // R12: after a flush both buffers are empty
   p_flush_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (rob_n == '0 && ren_v == '0));

   // R11: register writes from retirement only on a retire request
   p_ret_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ret_wr_en |-> ret_vld);
endmodule

bind disp_rename_stage drs_chk #(.G(G), .REN_D(REN_D), .ROB_D(ROB_D)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .ret_vld    (ret_vld),
   .disp_vld   (disp_vld),
   .slots_freed(slots_freed),
   .ret_wr_en  (ret_wr_en),
   .rob_n      (rob_n),
   .ren_n      (ren_n),
   .ren_v      (ren_v)
);

// File: tb/disp_rename_stage_tb_top.sv
module disp_rename_stage_tb_top;
   localparam int G = 4, AW = 5, DW = 32, REN_D = 8, ROB_D = 16;
   localparam int RTW = 3, QTW = 4, CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [G-1:0] grp_vld = '0, grp_dst_en = '0;
   logic [G-1:0][AW-1:0] grp_dst = '0;
   logic [G-1:0][1:0][AW-1:0] grp_src = '0;
   logic [G-1:0][1:0][AW-1:0] rf_addr;
   logic [G-1:0][1:0][DW-1:0] rf_data;
   logic wb_vld = 1'b0;
   logic [RTW-1:0] wb_tag = '0;
   logic [DW-1:0] wb_data = '0;
   logic ret_vld = 1'b0;
   logic [G-1:0] disp_vld;
   logic [G-1:0][QTW-1:0] disp_rob;
   logic [G-1:0][RTW-1:0] disp_tag;
   logic [G-1:0][1:0] opnd_rdy;
   logic [G-1:0][1:0][DW-1:0] opnd_val;
   logic [G-1:0][1:0][RTW-1:0] opnd_tag;
   logic [CW-1:0] slots_freed;
   logic ret_wr_en;
   logic [AW-1:0] ret_wr_reg;
   logic [DW-1:0] ret_wr_data;

   always #4 clk = ~clk;

   disp_rename_stage dut_i (.*);

   // Bench register file and reference state
   logic [DW-1:0] rf [32];
   always_comb
      for (int i = 0; i < G; i++)
         for (int s = 0; s < 2; s++)
            rf_data[i][s] = rf[rf_addr[i][s]];

   int m_arch [REN_D];
   bit m_v [REN_D];
   bit m_rdy [REN_D];
   logic [DW-1:0] m_val [REN_D];
   bit m_rob_has [ROB_D];
   int m_rob_tag [ROB_D];
   int m_rob_h, m_rob_t, m_rob_n, m_ren_h, m_ren_t, m_ren_n;
   int e_nd, e_acc;
   int e_ofs [G];
   int n_tests = 0, n_fail = 0;
   bit done = 0;
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < REN_D; k++) begin m_v[k] = 0; m_rdy[k] = 0; m_arch[k] = 0; m_val[k] = '0; end
      for (int q = 0; q < ROB_D; q++) begin m_rob_has[q] = 0; m_rob_tag[q] = 0; end
      m_rob_h = 0; m_rob_t = 0; m_rob_n = 0; m_ren_h = 0; m_ren_t = 0; m_ren_n = 0;
      for (int r = 0; r < 32; r++) rf[r] = 32'h1000 + r;
   endtask

   // Expected outputs from the requirements, compared every cycle
   task automatic compare_all();
      logic [G-1:0] ev = '0;
      bit go = !flush;
      e_acc = 0; e_nd = 0;
      for (int i = 0; i < G; i++) begin
         e_ofs[i] = e_acc;
         if (go && grp_vld[i] && m_rob_n + i + 1 <= ROB_D
             && m_ren_n + e_acc + int'(grp_dst_en[i]) <= REN_D) begin
            ev[i] = 1'b1; e_acc += int'(grp_dst_en[i]); e_nd = i + 1;
         end else go = 0;
      end
      chk("R2", "disp_vld", 64'(disp_vld), 64'(ev));
      chk("R9", "slots_freed", 64'(slots_freed), 64'(e_nd));
      for (int i = 0; i < e_nd; i++) begin
         chk("R3", "rob tag", 64'(disp_rob[i]), 64'((m_rob_h + i) % ROB_D));
         if (grp_dst_en[i]) chk("R4", "dest tag", 64'(disp_tag[i]), 64'((m_ren_h + e_ofs[i]) % REN_D));
         for (int s = 0; s < 2; s++) begin
            int src = int'(grp_src[i][s]);
            int gj = -1, best = -1, bage = -1;
            for (int j = 0; j < i; j++)
               if (grp_dst_en[j] && int'(grp_dst[j]) == src) gj = j;
            for (int k = 0; k < REN_D; k++)
               if (m_v[k] && m_arch[k] == src && (k - m_ren_t + REN_D) % REN_D > bage) begin
                  bage = (k - m_ren_t + REN_D) % REN_D; best = k;
               end
            if (gj >= 0) begin
               chk("R5", "group rdy", 64'(opnd_rdy[i][s]), 64'(0));
               chk("R5", "group tag", 64'(opnd_tag[i][s]), 64'((m_ren_h + e_ofs[gj]) % REN_D));
            end else if (best >= 0) begin
               chk("R6", "rename rdy", 64'(opnd_rdy[i][s]), 64'(m_rdy[best]));
               if (m_rdy[best]) chk("R6", "rename val", 64'(opnd_val[i][s]), 64'(m_val[best]));
               else chk("R6", "rename tag", 64'(opnd_tag[i][s]), 64'(best));
            end else begin
               chk("R7", "arch rdy", 64'(opnd_rdy[i][s]), 64'(1));
               chk("R7", "arch val", 64'(opnd_val[i][s]), 64'(rf[src]));
            end
         end
      end
      begin
         bit een = ret_vld && m_rob_n > 0 && m_rob_has[m_rob_t];
         chk("R11", "ret_wr_en", 64'(ret_wr_en), 64'(een));
         if (een) begin
            chk("R11", "ret_wr_reg", 64'(ret_wr_reg), 64'(m_arch[m_rob_tag[m_rob_t]]));
            chk("R11", "ret_wr_data", 64'(ret_wr_data), 64'(m_val[m_rob_tag[m_rob_t]]));
         end
      end
   endtask

   task automatic model_step();
      if (ret_vld && m_rob_n > 0) begin
         if (m_rob_has[m_rob_t]) begin
            int q = m_rob_tag[m_rob_t];
            rf[m_arch[q]] = m_val[q]; m_v[q] = 0;
            m_ren_t = (m_ren_t + 1) % REN_D; m_ren_n--;
         end
         m_rob_t = (m_rob_t + 1) % ROB_D; m_rob_n--;
      end
      if (wb_vld) begin m_rdy[wb_tag] = 1; m_val[wb_tag] = wb_data; end
      if (flush) begin
         for (int k = 0; k < REN_D; k++) m_v[k] = 0;
         m_ren_h = m_ren_t; m_ren_n = 0; m_rob_h = m_rob_t; m_rob_n = 0;
      end else begin
         for (int i = 0; i < e_nd; i++) begin
            int q = (m_rob_h + i) % ROB_D;
            int t = (m_ren_h + e_ofs[i]) % REN_D;
            m_rob_has[q] = grp_dst_en[i]; m_rob_tag[q] = t;
            if (grp_dst_en[i]) begin m_v[t] = 1; m_rdy[t] = 0; m_arch[t] = int'(grp_dst[i]); end
         end
         m_rob_h = (m_rob_h + e_nd) % ROB_D; m_rob_n += e_nd;
         m_ren_h = (m_ren_h + e_acc) % REN_D; m_ren_n += e_acc;
      end
   endtask

   task automatic settle(); #1; compare_all(); endtask
   task automatic advance(); @(posedge clk); model_step(); #1; endtask
   task automatic idle_in();
      flush = 0; grp_vld = '0; grp_dst_en = '0; grp_dst = '0; grp_src = '0;
      wb_vld = 0; wb_tag = '0; wb_data = '0; ret_vld = 0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: empty after reset, full no-destination group takes tags 0..3
      idle_in(); grp_vld = 4'b1111; grp_src[0][0] = 5'd5;
      settle();
      chk("R1", "first rob tag", 64'(disp_rob[0]), 64'(0));
      chk("R1", "last rob tag", 64'(disp_rob[3]), 64'(3));
      chk("R1", "all slots", 64'(slots_freed), 64'(4));
      advance();
      // R12: no dispatch while flushing
      flush = 1;
      settle();
      chk("R12", "flush blocks dispatch", 64'(disp_vld), 64'(0));
      advance();
      // R5/R7: intra-group forwarding and register-file path
      idle_in(); grp_vld = 4'b1111; grp_dst_en = 4'b1111;
      grp_dst[0] = 5'd1; grp_dst[1] = 5'd2; grp_dst[2] = 5'd1; grp_dst[3] = 5'd3;
      grp_src[1][0] = 5'd1; grp_src[3][0] = 5'd1; grp_src[2][1] = 5'd9;
      settle();
      chk("R5", "youngest older writer tag", 64'(opnd_tag[3][0]), 64'(2));
      chk("R5", "not ready", 64'(opnd_rdy[3][0]), 64'(0));
      chk("R7", "rf value", 64'(opnd_val[2][1]), 64'(32'h1009));
      advance();
      // R2/R6: gap at slot 1, rename hit not ready; write-back in same cycle
      idle_in(); grp_vld = 4'b1101; grp_dst_en = 4'b0001; grp_dst[0] = 5'd4; grp_src[0][0] = 5'd1;
      wb_vld = 1; wb_tag = 3'd2; wb_data = 32'hABCD;
      settle();
      chk("R2", "stop at first gap", 64'(disp_vld), 64'(4'b0001));
      chk("R6", "youngest rename tag", 64'(opnd_tag[0][0]), 64'(2));
      advance();
      // R10: value now ready
      idle_in(); grp_vld = 4'b0001; grp_src[0][0] = 5'd1;
      settle();
      chk("R10", "ready after write-back", 64'(opnd_rdy[0][0]), 64'(1));
      chk("R10", "value after write-back", 64'(opnd_val[0][0]), 64'(32'hABCD));
      advance();
      // R8: rename space runs out at slot 3
      idle_in(); grp_vld = 4'b1111; grp_dst_en = 4'b1111;
      for (int i = 0; i < G; i++) grp_dst[i] = AW'(5 + i);
      settle();
      chk("R8", "rename stall", 64'(disp_vld), 64'(4'b0111));
      advance();
      settle();
      chk("R8", "rename full", 64'(slots_freed), 64'(0));
      advance();
      grp_dst_en = '0;
      settle(); advance();
      settle();
      chk("R8", "reorder stall", 64'(disp_vld), 64'(4'b0111));
      advance();
      // R11: complete and retire the oldest entry
      idle_in(); wb_vld = 1; wb_tag = 3'd0; wb_data = 32'h55;
      settle(); advance();
      idle_in(); ret_vld = 1;
      settle();
      chk("R11", "retire write", 64'(ret_wr_en), 64'(1));
      chk("R11", "retire reg", 64'(ret_wr_reg), 64'(1));
      chk("R11", "retire data", 64'(ret_wr_data), 64'(32'h55));
      advance();
      // R12: after flush, lookups reach the register file
      idle_in(); flush = 1;
      settle(); advance();
      idle_in(); grp_vld = 4'b0001; grp_src[0][0] = 5'd4;
      settle();
      chk("R12", "lookup after flush rdy", 64'(opnd_rdy[0][0]), 64'(1));
      chk("R12", "lookup after flush val", 64'(opnd_val[0][0]), 64'(32'h1004));
      advance();
      // Sweep all valid/destination patterns with mixed traffic
      for (int pass = 0; pass < 3; pass++) begin
         for (int pat = 0; pat < 256; pat++) begin
            idle_in();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            grp_vld = pat[3:0]; grp_dst_en = pat[7:4];
            for (int i = 0; i < G; i++) begin
               grp_dst[i] = AW'((lf >> i) & 16'h7);
               grp_src[i][0] = AW'((lf >> (i + 4)) & 16'h7);
               grp_src[i][1] = AW'((lf >> (i + 8)) & 16'h7);
            end
            flush = (lf[4:0] == 5'd3);
            if (!flush && lf[9]) begin
               for (int d = 0; d < REN_D; d++) begin
                  int k = (d + int'(lf[2:0])) % REN_D;
                  if (!wb_vld && m_v[k] && !m_rdy[k]) begin
                     wb_vld = 1; wb_tag = RTW'(k); wb_data = {lf, lf ^ 16'h5A5A};
                  end
               end
            end
            if (m_rob_n > 0 && (lf[11] || lf[6]) &&
                (!m_rob_has[m_rob_t] || m_rdy[m_rob_tag[m_rob_t]]))
               ret_vld = 1;
            settle(); advance();
         end
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule